// File: doc/BRIEF.md
# Parallel SAR Converter Sequencer

This block drives a successive-approximation converter whose result comes out on a parallel bus. A start request causes it to pull the convert line low and then wait for the converter's busy flag to drop. It then drives chip-select and read low together and samples the bus once the access delay has passed. The result word goes out with a one-cycle valid strobe. In split mode the bus carries half a word at a time. The block reads the upper half with the byte-select line low, then raises byte-select, waits for the bus to settle and reads the lower half.

The same block also drives the converter's active-low power line. A short low pulse resets the converter. A long low pulse also powers it down. After either pulse the block waits out the wake-up time before it accepts a new conversion. Each timing limit is given in nanoseconds and turned into a whole number of clock cycles, rounded up, from the clock-period parameter. With the default 8 ns clock the counts are: convert low 3, convert high 13, start-to-start 32, read access 3, byte settle 3, reset pulse 13, power-down pulse 188, wake 625, busy timeout 250.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While reset is applied and just after it is released, the outputs are `convStN`=1, `csN`=1, `rdN`=1, `byteSel`=0, `pdN`=1, `resultValid`=0 and `timeoutErr`=0, and `ready`=1.
- R2: Each low pulse on `convStN` lasts at least 3 cycles (20 ns). Between pulses, `convStN` stays high for at least 13 cycles (100 ns).
- R3: Two falling edges of `convStN` are at least 32 cycles (250 ns) apart, even when `startReq` is held high.
- R4: `csN` and `rdN` always move together. They go low only after `adcBusy` has fallen, and never within 2 cycles (10 ns) of a `convStN` fall. The bus is sampled no earlier than 3 cycles (17 ns) after they go low.
- R5: When `splitMode` is 1 at the start, the first read takes `adcData[7:0]` with `byteSel`=0 as the upper byte. The block then raises `byteSel`, waits at least 3 cycles (20 ns) and takes `adcData[7:0]` as the lower byte. `result` is {upper, lower}.
- R6: When `splitMode` is 0, `result` takes all 16 bits of `adcData`. `resultValid` is high for exactly one cycle per conversion, and `result` holds its value until the next conversion finishes.
- R7: If `adcBusy` stays high for 250 cycles, `timeoutErr` pulses once. No read takes place, `resultValid` stays low and the block returns to idle.
- R8: A `startReq` that arrives while a conversion is in progress is ignored and causes no extra `convStN` pulse.
- R9: A `resetReq` accepted in idle drives `pdN` low for exactly 13 cycles (104 ns, inside the 20–500 ns reset-only window).
- R10: A `powerDownReq` accepted in idle drives `pdN` low for exactly 188 cycles (at least 1500 ns).
- R11: After `pdN` returns high, `ready` stays low and no `convStN` fall occurs for at least 625 cycles (5 µs).
- R12: When requests arrive together in idle, `powerDownReq` wins over `resetReq`, and `resetReq` wins over `startReq`. The losing requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Conversion request, taken only in idle |
| splitMode | input | 1 | 1: read the result as two 8-bit halves |
| resetReq | input | 1 | Request a reset-only pulse |
| powerDownReq | input | 1 | Request a power-down pulse |
| ready | output | 1 | Block is idle and accepts requests |
| resultValid | output | 1 | One-cycle strobe marking a new result |
| result | output | 16 | Last converted word |
| timeoutErr | output | 1 | One-cycle strobe: busy never fell |
| convStN | output | 1 | Active-low convert start |
| csN | output | 1 | Active-low chip select |
| rdN | output | 1 | Active-low read |
| byteSel | output | 1 | Half select in split mode (0 upper, 1 lower) |
| pdN | output | 1 | Active-low reset / power-down line |
| adcBusy | input | 1 | Converter busy flag (asynchronous) |
| adcData | input | 16 | Converter data bus |

## Verification
Every access-timing limit can only be seen through the value that ends up captured. For that reason the bench's converter model drives the inverted word until the modelled access delay or byte-settle delay has passed. A read that comes even one cycle early then shows up as a wrong `result`. The start-to-start guard is the hardest limit to reach, because a normal conversion takes longer than 250 ns. The bench therefore holds `startReq` high and makes the modelled conversion one cycle long, so that only the guard counter keeps the pulses apart.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CONV_LOW,
    S_BUSY_WAIT,
    S_READ1,
    S_READ2,
    S_RECOVER,
    S_PD_LOW,
    S_WAKE
  } ctlState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clrTimer;
    logic clrPeriod;
    logic convLow;
    logic capFull;
    logic capHigh;
    logic capLow;
  } ctlStrobe_t;

  function automatic int cyclesFor(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_ctl_datapath.sv
module adc_ctl_datapath
  import adc_ctl_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int HALF_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int TIMER_W      = 10,
  parameter int PERIOD_CYC   = 32,
  parameter int HIGH_CYC     = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              adcBusy,
  input  logic [DATA_W-1:0] adcData,
  output logic [TIMER_W-1:0] timer,
  output logic              busySync,
  output logic              periodDone,
  output logic              highDone,
  output logic              resultValid,
  output logic [DATA_W-1:0] result
);

  localparam int PERIOD_W = $clog2(PERIOD_CYC + 1);
  localparam int HIGH_W   = $clog2(HIGH_CYC + 1);
  localparam logic [PERIOD_W-1:0] PERIOD_LAST = PERIOD_W'(PERIOD_CYC - 1);
  localparam logic [HIGH_W-1:0]   HIGH_LAST   = HIGH_W'(HIGH_CYC - 1);

  // busy synchroniser, depth chosen by parameter
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= adcBusy;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], adcBusy};
      end
    end
  endgenerate
  assign busySync = syncQ[SYNC_STAGES-1];

  // state timer, cleared on every state change, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               timer <= '0;
    else if (strb.clrTimer)  timer <= '0;
    else if (timer != '1)    timer <= timer + 1'b1;
  end

  // cycles since the last convert-start fall
  logic [PERIOD_W-1:0] periodCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      periodCnt <= PERIOD_LAST;
    else if (strb.clrPeriod)        periodCnt <= '0;
    else if (periodCnt != PERIOD_LAST) periodCnt <= periodCnt + 1'b1;
  end
  assign periodDone = (periodCnt == PERIOD_LAST);

  // cycles the convert-start line has been high
  logic [HIGH_W-1:0] highCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  highCnt <= HIGH_LAST;
    else if (strb.convLow)      highCnt <= '0;
    else if (highCnt != HIGH_LAST) highCnt <= highCnt + 1'b1;
  end
  assign highDone = (highCnt == HIGH_LAST);

  // capture registers
  logic [HALF_W-1:0] upperQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ      <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strb.capFull | strb.capLow;
      if (strb.capHigh) upperQ <= adcData[HALF_W-1:0];
      if (strb.capFull) result <= adcData;
      if (strb.capLow)  result <= {upperQ, adcData[HALF_W-1:0]};
    end
  end

  AST_CAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capFull, strb.capHigh, strb.capLow})); // R6
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R6

endmodule

// File: rtl/adc_ctl_fsm.sv
module adc_ctl_fsm
  import adc_ctl_pkg::*;
#(
  parameter int TIMER_W          = 10,
  parameter int CONV_LOW_CYC     = 3,
  parameter int BUSY_MASK_CYC    = 4,
  parameter int BUSY_TIMEOUT_CYC = 250,
  parameter int READ_ACC_CYC     = 3,
  parameter int BYTE_SET_CYC     = 3,
  parameter int GAP_CYC          = 4,
  parameter int RST_PULSE_CYC    = 13,
  parameter int PD_PULSE_CYC     = 188,
  parameter int WAKE_CYC         = 625
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               splitMode,
  input  logic               resetReq,
  input  logic               powerDownReq,
  input  logic [TIMER_W-1:0] timer,
  input  logic               busySync,
  input  logic               periodDone,
  input  logic               highDone,
  output ctlStrobe_t         strb,
  output logic               ready,
  output logic               timeoutErr,
  output logic               convStN,
  output logic               csN,
  output logic               rdN,
  output logic               byteSel,
  output logic               pdN
);

  localparam logic [TIMER_W-1:0] T_CONV_LOW = TIMER_W'(CONV_LOW_CYC - 1);
  localparam logic [TIMER_W-1:0] T_MASK     = TIMER_W'(BUSY_MASK_CYC - 1);
  localparam logic [TIMER_W-1:0] T_TIMEOUT  = TIMER_W'(BUSY_TIMEOUT_CYC - 1);
  localparam logic [TIMER_W-1:0] T_READ     = TIMER_W'(READ_ACC_CYC - 1);
  localparam logic [TIMER_W-1:0] T_BYTE     = TIMER_W'(BYTE_SET_CYC - 1);
  localparam logic [TIMER_W-1:0] T_GAP      = TIMER_W'(GAP_CYC - 1);
  localparam logic [TIMER_W-1:0] T_RST      = TIMER_W'(RST_PULSE_CYC - 1);
  localparam logic [TIMER_W-1:0] T_PD       = TIMER_W'(PD_PULSE_CYC - 1);
  localparam logic [TIMER_W-1:0] T_WAKE     = TIMER_W'(WAKE_CYC - 1);

  ctlState_t state, nextState;
  logic splitQ, splitNext;
  logic longPdQ, longPdNext;
  logic timeoutHit;

  always_comb begin
    nextState  = state;
    splitNext  = splitQ;
    longPdNext = longPdQ;
    timeoutHit = 1'b0;
    strb       = '0;
    case (state)
      S_IDLE: begin
        if (powerDownReq) begin
          nextState  = S_PD_LOW;
          longPdNext = 1'b1;
        end else if (resetReq) begin
          nextState  = S_PD_LOW;
          longPdNext = 1'b0;
        end else if (startReq) begin
          nextState      = S_CONV_LOW;
          splitNext      = splitMode;
          strb.clrPeriod = 1'b1;
        end
      end
      S_CONV_LOW: begin
        strb.convLow = 1'b1;
        if (timer >= T_CONV_LOW) nextState = S_BUSY_WAIT;
      end
      S_BUSY_WAIT: begin
        if (timer >= T_MASK && !busySync) begin
          nextState = S_READ1;
        end else if (timer >= T_TIMEOUT) begin
          nextState  = S_RECOVER;
          timeoutHit = 1'b1;
        end
      end
      S_READ1: begin
        if (timer >= T_READ) begin
          if (splitQ) begin
            strb.capHigh = 1'b1;
            nextState    = S_READ2;
          end else begin
            strb.capFull = 1'b1;
            nextState    = S_RECOVER;
          end
        end
      end
      S_READ2: begin
        if (timer >= T_BYTE) begin
          strb.capLow = 1'b1;
          nextState   = S_RECOVER;
        end
      end
      S_RECOVER: begin
        if (timer >= T_GAP && periodDone && highDone) nextState = S_IDLE;
      end
      S_PD_LOW: begin
        if (timer >= (longPdQ ? T_PD : T_RST)) nextState = S_WAKE;
      end
      S_WAKE: begin
        if (timer >= T_WAKE) nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
    strb.clrTimer = (nextState != state);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      splitQ     <= 1'b0;
      longPdQ    <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      state      <= nextState;
      splitQ     <= splitNext;
      longPdQ    <= longPdNext;
      timeoutErr <= timeoutHit;
    end
  end

  assign ready   = (state == S_IDLE);
  assign convStN = (state != S_CONV_LOW);
  assign csN     = !((state == S_READ1) || (state == S_READ2));
  assign rdN     = csN;
  assign byteSel = (state == S_READ2);
  assign pdN     = (state != S_PD_LOW);

  AST_CONV_LOW_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convStN) |-> ($past(timer) == T_CONV_LOW)); // R2
  AST_PERIOD_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convStN) |-> ($past(periodDone) && $past(highDone))); // R3
  AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (!$past(busySync) && $past(timer) >= T_MASK)); // R4
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(convStN) |-> ($past(state) == S_IDLE)); // R8
  AST_PD_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdN) |-> ($past(timer) == T_RST || $past(timer) == T_PD)); // R9

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int DATA_W          = 16,
  parameter int SYNC_STAGES     = 2,
  parameter int CLK_PERIOD_NS   = 8,
  parameter int CONV_LOW_NS     = 20,
  parameter int CONV_HIGH_NS    = 100,
  parameter int CONV_PERIOD_NS  = 250,
  parameter int QUIET_PRE_NS    = 30,
  parameter int QUIET_POST_NS   = 10,
  parameter int READ_ACCESS_NS  = 17,
  parameter int BYTE_SETTLE_NS  = 20,
  parameter int BUS_RELEASE_NS  = 12,
  parameter int RESET_PULSE_NS  = 100,
  parameter int PD_PULSE_NS     = 1500,
  parameter int WAKE_NS         = 5000,
  parameter int BUSY_TIMEOUT_NS = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              splitMode,
  input  logic              resetReq,
  input  logic              powerDownReq,
  output logic              ready,
  output logic              resultValid,
  output logic [DATA_W-1:0] result,
  output logic              timeoutErr,
  output logic              convStN,
  output logic              csN,
  output logic              rdN,
  output logic              byteSel,
  output logic              pdN,
  input  logic              adcBusy,
  input  logic [DATA_W-1:0] adcData
);

  localparam int HALF_W           = DATA_W / 2;
  localparam int CONV_LOW_CYC     = cyclesFor(CONV_LOW_NS, CLK_PERIOD_NS);
  localparam int HIGH_CYC         = cyclesFor(CONV_HIGH_NS, CLK_PERIOD_NS);
  localparam int PERIOD_CYC       = cyclesFor(CONV_PERIOD_NS, CLK_PERIOD_NS);
  localparam int QUIET_PRE_CYC    = cyclesFor(QUIET_PRE_NS, CLK_PERIOD_NS);
  localparam int QUIET_POST_CYC   = cyclesFor(QUIET_POST_NS, CLK_PERIOD_NS);
  localparam int READ_ACC_CYC     = cyclesFor(READ_ACCESS_NS, CLK_PERIOD_NS);
  localparam int BYTE_SET_CYC     = cyclesFor(BYTE_SETTLE_NS, CLK_PERIOD_NS);
  localparam int RELEASE_CYC      = cyclesFor(BUS_RELEASE_NS, CLK_PERIOD_NS);
  localparam int RST_PULSE_CYC    = cyclesFor(RESET_PULSE_NS, CLK_PERIOD_NS);
  localparam int PD_PULSE_CYC     = cyclesFor(PD_PULSE_NS, CLK_PERIOD_NS);
  localparam int WAKE_CYC         = cyclesFor(WAKE_NS, CLK_PERIOD_NS);
  localparam int BUSY_TIMEOUT_CYC = cyclesFor(BUSY_TIMEOUT_NS, CLK_PERIOD_NS);
  localparam int GAP_CYC          = maxOf(QUIET_PRE_CYC, RELEASE_CYC);
  localparam int BUSY_MASK_CYC    = maxOf(QUIET_POST_CYC, SYNC_STAGES + 2);
  localparam int MAX_CYC          = maxOf(maxOf(WAKE_CYC, PD_PULSE_CYC),
                                          maxOf(BUSY_TIMEOUT_CYC, PERIOD_CYC));
  localparam int TIMER_W          = $clog2(MAX_CYC + 1);

  ctlStrobe_t         strb;
  logic [TIMER_W-1:0] timer;
  logic               busySync;
  logic               periodDone;
  logic               highDone;

  adc_ctl_fsm #(
    .TIMER_W         (TIMER_W),
    .CONV_LOW_CYC    (CONV_LOW_CYC),
    .BUSY_MASK_CYC   (BUSY_MASK_CYC),
    .BUSY_TIMEOUT_CYC(BUSY_TIMEOUT_CYC),
    .READ_ACC_CYC    (READ_ACC_CYC),
    .BYTE_SET_CYC    (BYTE_SET_CYC),
    .GAP_CYC         (GAP_CYC),
    .RST_PULSE_CYC   (RST_PULSE_CYC),
    .PD_PULSE_CYC    (PD_PULSE_CYC),
    .WAKE_CYC        (WAKE_CYC)
  ) u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .splitMode   (splitMode),
    .resetReq    (resetReq),
    .powerDownReq(powerDownReq),
    .timer       (timer),
    .busySync    (busySync),
    .periodDone  (periodDone),
    .highDone    (highDone),
    .strb        (strb),
    .ready       (ready),
    .timeoutErr  (timeoutErr),
    .convStN     (convStN),
    .csN         (csN),
    .rdN         (rdN),
    .byteSel     (byteSel),
    .pdN         (pdN)
  );

  adc_ctl_datapath #(
    .DATA_W     (DATA_W),
    .HALF_W     (HALF_W),
    .SYNC_STAGES(SYNC_STAGES),
    .TIMER_W    (TIMER_W),
    .PERIOD_CYC (PERIOD_CYC),
    .HIGH_CYC   (HIGH_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .adcBusy    (adcBusy),
    .adcData    (adcData),
    .timer      (timer),
    .busySync   (busySync),
    .periodDone (periodDone),
    .highDone   (highDone),
    .resultValid(resultValid),
    .result     (result)
  );

endmodule

// File: tb/adc_conv_ctrl_tb.sv
module adc_conv_ctrl_tb;

  localparam int CLK_NS       = 8;
  localparam int CONV_LOW_EXP = (20 + CLK_NS - 1) / CLK_NS;
  localparam int HIGH_EXP     = (100 + CLK_NS - 1) / CLK_NS;
  localparam int PERIOD_EXP   = (250 + CLK_NS - 1) / CLK_NS;
  localparam int QPOST_EXP    = (10 + CLK_NS - 1) / CLK_NS;
  localparam int RST_EXP      = (100 + CLK_NS - 1) / CLK_NS;
  localparam int PD_EXP       = (1500 + CLK_NS - 1) / CLK_NS;
  localparam int WAKE_EXP     = (5000 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, splitMode = 1'b0, resetReq = 1'b0, powerDownReq = 1'b0;
  logic ready, resultValid, timeoutErr, convStN, csN, rdN, byteSel, pdN;
  logic [15:0] result;
  logic adcBusy = 1'b0;
  logic [15:0] adcData;

  always #(CLK_NS / 2) clk = ~clk;

  adc_conv_ctrl u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .splitMode(splitMode),
    .resetReq(resetReq), .powerDownReq(powerDownReq), .ready(ready),
    .resultValid(resultValid), .result(result), .timeoutErr(timeoutErr),
    .convStN(convStN), .csN(csN), .rdN(rdN), .byteSel(byteSel), .pdN(pdN),
    .adcBusy(adcBusy), .adcData(adcData)
  );

  int numChecks = 0, numFail = 0;
  bit finished = 0;

  // converter model state
  logic [15:0] modelWord = 16'h0;
  int  convLen = 28;
  bit  stuck = 0;
  int  busyLeft = 0;
  int  accCnt = 0, byteCnt = 100;

  // monitor state
  int  cyc = 0;
  logic convPrev = 1, csPrev = 1, pdPrev = 1, readyPrev = 1, bsPrev = 0;
  int  lowRun = 0, highRun = 0, pdRun = 0;
  int  lastLowW = 0, lastHighW = 1000, lastPeriod = 1000, minPeriod = 1000, minHigh = 1000;
  int  lastFallCyc = -1000, lastPdRiseCyc = 0, lastPdW = 0, wakeGap = 0, firstFallAfterPd = 0;
  int  convFalls = 0, csFalls = 0, validCount = 0, errCount = 0, accessViol = 0;
  logic [15:0] lastResult = 0;

  wire accOk  = (accCnt * CLK_NS >= 17);
  wire byteOk = (byteCnt * CLK_NS >= 20);
  wire [15:0] goodBus = splitMode ? (byteSel ? {8'h00, modelWord[7:0]} : {8'h00, modelWord[15:8]})
                                  : modelWord;
  assign adcData = (accOk && byteOk) ? goodBus : ~goodBus;

  always @(negedge clk) begin
    if (rstN) begin
      cyc = cyc + 1;
      // convert line
      if (convPrev && !convStN) begin
        convFalls  = convFalls + 1;
        lastHighW  = highRun;
        if (highRun < minHigh) minHigh = highRun;
        lastPeriod = cyc - lastFallCyc;
        if (lastPeriod < minPeriod) minPeriod = lastPeriod;
        lastFallCyc = cyc;
        if (cyc - lastPdRiseCyc < firstFallAfterPd || firstFallAfterPd == 0)
          firstFallAfterPd = cyc - lastPdRiseCyc;
        lowRun = 0;
        adcBusy = 1'b1;
        busyLeft = convLen;
      end else if (adcBusy && !stuck) begin
        if (busyLeft <= 1) adcBusy = 1'b0;
        else busyLeft = busyLeft - 1;
      end
      if (!convPrev && convStN) begin lastLowW = lowRun; highRun = 0; end
      if (!convStN) lowRun = lowRun + 1; else highRun = highRun + 1;
      // read access
      if (csN != rdN) accessViol = accessViol + 1;
      if (csPrev && !csN) begin
        csFalls = csFalls + 1;
        if (adcBusy) accessViol = accessViol + 1;
        if (cyc - lastFallCyc < QPOST_EXP) accessViol = accessViol + 1;
      end
      if (!csN && !rdN) accCnt = accCnt + 1; else accCnt = 0;
      if (byteSel != bsPrev) byteCnt = 1; else if (byteCnt < 100) byteCnt = byteCnt + 1;
      // power line
      if (!pdN) pdRun = pdRun + 1;
      if (!pdPrev && pdN) begin lastPdW = pdRun; pdRun = 0; lastPdRiseCyc = cyc; firstFallAfterPd = 0; end
      if (!readyPrev && ready && pdPrev && pdN && lastPdRiseCyc != 0) wakeGap = cyc - lastPdRiseCyc;
      if (resultValid) begin validCount = validCount + 1; lastResult = result; end
      if (timeoutErr) errCount = errCount + 1;
      convPrev = convStN; csPrev = csN; pdPrev = pdN; readyPrev = ready; bsPrev = byteSel;
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    numChecks++;
    if (act != exp) begin
      numFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAtLeast(input string req, input string what, input longint act, input longint lim);
    numChecks++;
    if (act < lim) begin
      numFail++;
      $display("FAIL %s %s actual=%0d expected>=%0d", req, what, act, lim);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 2000 && !ready; i++) tick(1);
  endtask

  task automatic waitDone(input int v0, input int e0);
    for (int i = 0; i < 1000 && validCount == v0 && errCount == e0; i++) tick(1);
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    #1;
  endtask

  task automatic testReset();
    check("R1", "convStN", convStN, 1);
    check("R1", "csN", csN, 1);
    check("R1", "rdN", rdN, 1);
    check("R1", "byteSel", byteSel, 0);
    check("R1", "pdN", pdN, 1);
    check("R1", "resultValid", resultValid, 0);
    check("R1", "timeoutErr", timeoutErr, 0);
    check("R1", "ready", ready, 1);
  endtask

  task automatic testFullRead(input logic [15:0] w);
    int v0, a0;
    waitReady();
    modelWord = w; splitMode = 1'b0; convLen = 28;
    v0 = validCount; a0 = accessViol;
    pulseStart();
    waitDone(v0, errCount);
    tick(2);
    check("R6", "full result", lastResult, w);
    check("R6", "valid count", validCount - v0, 1);
    checkAtLeast("R2", "convert low width", lastLowW, CONV_LOW_EXP);
    check("R4", "access violations", accessViol - a0, 0);
    tick(5);
    check("R6", "result held", result, w);
  endtask

  task automatic testSplitRead(input logic [15:0] w);
    int v0;
    waitReady();
    modelWord = w; splitMode = 1'b1; convLen = 20;
    v0 = validCount;
    pulseStart();
    waitDone(v0, errCount);
    tick(2);
    check("R5", "split result", lastResult, w);
    check("R5", "valid count", validCount - v0, 1);
    splitMode = 1'b0;
  endtask

  task automatic testBackToBack();
    int f0, v0;
    waitReady();
    modelWord = 16'h3C5A; convLen = 1;
    minPeriod = 1000; minHigh = 1000;
    f0 = convFalls; v0 = validCount;
    @(negedge clk); startReq = 1'b1;
    for (int i = 0; i < 400 && convFalls - f0 < 4; i++) tick(1);
    @(negedge clk); startReq = 1'b0;
    tick(80);
    checkAtLeast("R3", "min start spacing", minPeriod, PERIOD_EXP);
    checkAtLeast("R2", "min convert high", minHigh, HIGH_EXP);
    check("R6", "back-to-back result", lastResult, 16'h3C5A);
    checkAtLeast("R3", "conversions run", convFalls - f0, 4);
  endtask

  task automatic testIgnoreStart();
    int f0, v0;
    waitReady();
    modelWord = 16'hA55A; convLen = 28;
    f0 = convFalls; v0 = validCount;
    pulseStart();
    tick(6);
    pulseStart();
    tick(10);
    pulseStart();
    waitDone(v0, errCount);
    tick(60);
    check("R8", "convert pulses", convFalls - f0, 1);
    check("R8", "results", validCount - v0, 1);
  endtask

  task automatic testTimeout();
    int v0, e0, c0;
    waitReady();
    stuck = 1; convLen = 28;
    v0 = validCount; e0 = errCount; c0 = csFalls;
    pulseStart();
    waitDone(v0, e0);
    tick(2);
    check("R7", "timeout pulses", errCount - e0, 1);
    check("R7", "no result", validCount - v0, 0);
    check("R7", "no read", csFalls - c0, 0);
    stuck = 0;
    waitReady();
    check("R7", "back to idle", ready, 1);
  endtask

  task automatic testResetPulse();
    int f0;
    waitReady();
    f0 = convFalls;
    @(negedge clk); resetReq = 1'b1; startReq = 1'b1;
    @(negedge clk); resetReq = 1'b0; startReq = 1'b0;
    waitReady();
    tick(2);
    check("R9", "reset pulse width", lastPdW, RST_EXP);
    check("R12", "start lost to reset", convFalls - f0, 0);
    checkAtLeast("R11", "wake after reset", wakeGap, WAKE_EXP);
  endtask

  task automatic testPowerDown();
    int f0, v0;
    waitReady();
    f0 = convFalls;
    @(negedge clk); powerDownReq = 1'b1; resetReq = 1'b1; startReq = 1'b1;
    @(negedge clk); powerDownReq = 1'b0; resetReq = 1'b0;
    // keep start asserted through the wake window
    modelWord = 16'h1234; convLen = 28;
    v0 = validCount;
    for (int i = 0; i < 2000 && convFalls == f0 + 0; i++) tick(1);
    @(negedge clk); startReq = 1'b0;
    waitDone(v0, errCount);
    tick(2);
    check("R10", "power-down pulse width", lastPdW, PD_EXP);
    check("R12", "power-down wins", lastPdW, PD_EXP);
    checkAtLeast("R11", "first start after wake", firstFallAfterPd, WAKE_EXP);
    check("R11", "result after wake", lastResult, 16'h1234);
  endtask

  initial begin
    for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      numChecks++; numFail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("%0d/%0d checks passed", numChecks - numFail, numChecks);
      $finish;
    end
  end

  initial begin
    tick(5);
    testReset();
    rstN = 1'b1;
    tick(2);
    testReset();
    testFullRead(16'hBEEF);
    testFullRead(16'h0001);
    testSplitRead(16'hC3A5);
    testSplitRead(16'h7E01);
    testBackToBack();
    testIgnoreStart();
    testTimeout();
    testResetPulse();
    testPowerDown();
    finished = 1;
    $display("%0d/%0d checks passed", numChecks - numFail, numChecks);
    $finish;
  end

endmodule